// File: doc/BRIEF.md
# Segmented Effective Address Generator

This block turns the addressing-mode byte of a 16-bit instruction into an operand location. From the byte it works out whether the operand sits in a register or in memory. For a memory operand it adds up any displacement, base register and index register to give a 16-bit effective address. It then chooses a segment and forms the 20-bit physical address as segment times sixteen plus offset.

The decode stage presents the addressing byte, the raw displacement field, the four pointer registers and the four segment registers, plus an optional segment-override selector. The block returns the register codes, a register-operand flag, the effective address, the chosen segment and the physical address. By default the result is registered, one clock after the request. A parameter selects a purely combinational variant.

Top module: `seg_ea_gen`

## Requirements
- R1: The addressing byte holds mode in bits 7:6, the register field in bits 5:3 and the r/m field in bits 2:0. `reg_code` returns bits 5:3 and `rm_code` returns bits 2:0 for every byte.
- R2: For modes 00, 01 and 10, r/m selects the address terms. 000 is base_x+idx_s, 001 is base_x+idx_d, 010 is base_p+idx_s and 011 is base_p+idx_d. 100 is idx_s alone, 101 is idx_d alone, 110 is base_p alone and 111 is base_x alone.
- R3: Mode 11 marks a register operand. `is_reg` is 1, `eff_addr` is 0, `phys_addr` is 0 and `seg_code` is the data-segment code 11.
- R4: Mode 00 adds no displacement. Mode 01 adds `disp[7:0]` sign-extended to 16 bits, and `disp[15:8]` has no effect. Mode 10 adds all 16 bits of `disp`.
- R5: Mode 00 with r/m 110 is a direct address. `eff_addr` equals `disp`, no register is added, and the default segment is the data segment.
- R6: With no override, any memory form whose address includes base_p uses the stack segment (code 10). Every other memory form uses the data segment (code 11).
- R7: When `ovr_en` is 1, a memory operand uses the segment named by `ovr_sel`. The segment codes are 00 extra, 01 code, 10 stack and 11 data.
- R8: `phys_addr` = (selected segment value × 16 + `eff_addr`) mod 2^20. For example, segment 93EE with offset DB1E gives A19FE.
- R9: The effective-address sum wraps modulo 2^16.
- R10: In the registered variant, the outputs and `out_valid` reflect the request sampled at the previous rising edge. Reset clears `out_valid` and all outputs to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Request present |
| modrm | input | 8 | Addressing-mode byte |
| disp | input | 16 | Raw displacement field (low byte only for 8-bit form) |
| base_x | input | 16 | General base register value |
| base_p | input | 16 | Stack-frame base register value |
| idx_s | input | 16 | Source index register value |
| idx_d | input | 16 | Destination index register value |
| seg_es | input | 16 | Extra segment value |
| seg_cs | input | 16 | Code segment value |
| seg_ss | input | 16 | Stack segment value |
| seg_ds | input | 16 | Data segment value |
| ovr_en | input | 1 | Segment override present |
| ovr_sel | input | 2 | Override segment code |
| out_valid | output | 1 | Result present |
| is_reg | output | 1 | Operand is a register |
| reg_code | output | 3 | Register field |
| rm_code | output | 3 | r/m field |
| eff_addr | output | 16 | Effective address |
| seg_code | output | 2 | Selected segment code |
| phys_addr | output | 20 | Physical address |

## Verification
The clocked assertions assume that `in_valid` and the request fields are steady across each rising edge. They also assume that reset is asserted before the first request. The stimulus changes inputs only on falling edges and holds them for a full cycle. The sweep covers all 256 addressing bytes against several register and displacement patterns, with and without each override code. Register patterns include values near 0xFFFF, so that the wrap cases of the offset sum and of the physical sum are driven.

// File: rtl/seg_ea_pkg.sv
package seg_ea_pkg;
   typedef enum logic [1:0] {
      SEG_EXTRA = 2'b00,
      SEG_CODE  = 2'b01,
      SEG_STACK = 2'b10,
      SEG_DATA  = 2'b11
   } seg_code_e;

   typedef enum logic [1:0] {
      DSP_NONE = 2'b00,
      DSP_S8   = 2'b01,
      DSP_FULL = 2'b10
   } disp_kind_e;

   typedef struct packed {
      logic       is_reg;
      logic       use_base;
      logic       base_is_p;
      logic       use_index;
      logic       index_is_d;
      disp_kind_e dkind;
   } ea_decode_t;
endpackage

// File: rtl/seg_ea_decode.sv
module seg_ea_decode
   import seg_ea_pkg::*;
(
   input  logic [7:0]  modrm,
   output ea_decode_t  dec
);
   logic [1:0] mode;
   logic [2:0] rm;

   assign mode = modrm[7:6];
   assign rm   = modrm[2:0];

   always_comb begin
      dec = '0;
      dec.dkind = DSP_NONE;
      if (mode == 2'b11) begin
         dec.is_reg = 1'b1;
      end else begin
         unique case (rm)
            3'b000: begin dec.use_base = 1'b1; dec.use_index = 1'b1; end
            3'b001: begin dec.use_base = 1'b1; dec.use_index = 1'b1; dec.index_is_d = 1'b1; end
            3'b010: begin dec.use_base = 1'b1; dec.base_is_p = 1'b1; dec.use_index = 1'b1; end
            3'b011: begin dec.use_base = 1'b1; dec.base_is_p = 1'b1; dec.use_index = 1'b1; dec.index_is_d = 1'b1; end
            3'b100: dec.use_index = 1'b1;
            3'b101: begin dec.use_index = 1'b1; dec.index_is_d = 1'b1; end
            3'b110: begin
               dec.use_base  = (mode != 2'b00);
               dec.base_is_p = (mode != 2'b00);
            end
            default: dec.use_base = 1'b1;
         endcase
         unique case (mode)
            2'b01:   dec.dkind = DSP_S8;
            2'b10:   dec.dkind = DSP_FULL;
            default: dec.dkind = (rm == 3'b110) ? DSP_FULL : DSP_NONE;
         endcase
      end
   end

   // R3: a register operand never requests address terms
   always_comb begin
      p_regop_no_terms_r3: assert (!(dec.is_reg && (dec.use_base || dec.use_index)));
   end
endmodule

// File: rtl/seg_ea_offset.sv
module seg_ea_offset
   import seg_ea_pkg::*;
#(
   parameter int OFS_W = 16
)(
   input  ea_decode_t        dec,
   input  logic [OFS_W-1:0]  disp,
   input  logic [OFS_W-1:0]  base_x,
   input  logic [OFS_W-1:0]  base_p,
   input  logic [OFS_W-1:0]  idx_s,
   input  logic [OFS_W-1:0]  idx_d,
   output logic [OFS_W-1:0]  offset
);
   localparam int EXT_W = OFS_W - 8;

   logic [OFS_W-1:0] base_term, index_term, disp_term;

   always_comb begin
      base_term  = '0;
      index_term = '0;
      disp_term  = '0;
      if (dec.use_base)  base_term  = dec.base_is_p  ? base_p : base_x;
      if (dec.use_index) index_term = dec.index_is_d ? idx_d  : idx_s;
      unique case (dec.dkind)
         DSP_S8:   disp_term = {{EXT_W{disp[7]}}, disp[7:0]};
         DSP_FULL: disp_term = disp;
         default:  disp_term = '0;
      endcase
   end

   // R9: truncation to OFS_W bits gives the modular wrap
   assign offset = base_term + index_term + disp_term;
endmodule

// File: rtl/seg_ea_segsel.sv
module seg_ea_segsel
   import seg_ea_pkg::*;
#(
   parameter int OFS_W = 16
)(
   input  ea_decode_t        dec,
   input  logic              ovr_en,
   input  logic [1:0]        ovr_sel,
   input  logic [OFS_W-1:0]  seg_es,
   input  logic [OFS_W-1:0]  seg_cs,
   input  logic [OFS_W-1:0]  seg_ss,
   input  logic [OFS_W-1:0]  seg_ds,
   output seg_code_e         seg_code,
   output logic [OFS_W-1:0]  seg_val
);
   always_comb begin
      if (dec.is_reg)                       seg_code = SEG_DATA;
      else if (ovr_en)                      seg_code = seg_code_e'(ovr_sel);
      else if (dec.use_base && dec.base_is_p) seg_code = SEG_STACK;
      else                                  seg_code = SEG_DATA;
      unique case (seg_code)
         SEG_EXTRA: seg_val = seg_es;
         SEG_CODE:  seg_val = seg_cs;
         SEG_STACK: seg_val = seg_ss;
         default:   seg_val = seg_ds;
      endcase
   end
endmodule

// File: rtl/seg_ea_phys.sv
module seg_ea_phys #(
   parameter int OFS_W     = 16,
   parameter int SEG_SHIFT = 4
)(
   input  logic [OFS_W-1:0]            seg_val,
   input  logic [OFS_W-1:0]            offset,
   output logic [OFS_W+SEG_SHIFT-1:0]  phys
);
   localparam int PA_W = OFS_W + SEG_SHIFT;

   logic [PA_W-1:0] seg_scaled, ofs_ext;
   assign seg_scaled = {seg_val, {SEG_SHIFT{1'b0}}};
   assign ofs_ext    = {{SEG_SHIFT{1'b0}}, offset};
   assign phys       = seg_scaled + ofs_ext;

   // R8: the low SEG_SHIFT bits come from the offset alone
   always_comb begin
      p_low_bits_r8: assert (phys[SEG_SHIFT-1:0] == offset[SEG_SHIFT-1:0]);
   end
endmodule

// File: rtl/seg_ea_gen.sv
module seg_ea_gen
   import seg_ea_pkg::*;
#(
   parameter int OFS_W     = 16,
   parameter int SEG_SHIFT = 4,
   parameter bit OUT_REG   = 1'b1
)(
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        in_valid,
   input  logic [7:0]                  modrm,
   input  logic [OFS_W-1:0]            disp,
   input  logic [OFS_W-1:0]            base_x,
   input  logic [OFS_W-1:0]            base_p,
   input  logic [OFS_W-1:0]            idx_s,
   input  logic [OFS_W-1:0]            idx_d,
   input  logic [OFS_W-1:0]            seg_es,
   input  logic [OFS_W-1:0]            seg_cs,
   input  logic [OFS_W-1:0]            seg_ss,
   input  logic [OFS_W-1:0]            seg_ds,
   input  logic                        ovr_en,
   input  logic [1:0]                  ovr_sel,
   output logic                        out_valid,
   output logic                        is_reg,
   output logic [2:0]                  reg_code,
   output logic [2:0]                  rm_code,
   output logic [OFS_W-1:0]            eff_addr,
   output logic [1:0]                  seg_code,
   output logic [OFS_W+SEG_SHIFT-1:0]  phys_addr
);
   localparam int PA_W = OFS_W + SEG_SHIFT;

   generate
      if (OFS_W < 9)      begin : g_bad_ofs   $error("OFS_W must exceed the 8-bit displacement"); end
      if (SEG_SHIFT < 1)  begin : g_bad_shift $error("SEG_SHIFT must be at least 1"); end
   endgenerate

   ea_decode_t       dec;
   logic [OFS_W-1:0] ofs_raw, seg_val;
   seg_code_e        seg_sel;
   logic [PA_W-1:0]  phys_raw;

   seg_ea_decode u_dec (.modrm(modrm), .dec(dec));

   seg_ea_offset #(.OFS_W(OFS_W)) u_ofs (
      .dec(dec), .disp(disp), .base_x(base_x), .base_p(base_p),
      .idx_s(idx_s), .idx_d(idx_d), .offset(ofs_raw));

   seg_ea_segsel #(.OFS_W(OFS_W)) u_seg (
      .dec(dec), .ovr_en(ovr_en), .ovr_sel(ovr_sel),
      .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
      .seg_code(seg_sel), .seg_val(seg_val));

   seg_ea_phys #(.OFS_W(OFS_W), .SEG_SHIFT(SEG_SHIFT)) u_phys (
      .seg_val(seg_val), .offset(ofs_raw), .phys(phys_raw));

   logic             n_reg;
   logic [OFS_W-1:0] n_ea;
   logic [PA_W-1:0]  n_pa;
   assign n_reg = dec.is_reg;
   assign n_ea  = dec.is_reg ? '0 : ofs_raw;
   assign n_pa  = dec.is_reg ? '0 : phys_raw;

   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               out_valid <= 1'b0;
               is_reg    <= 1'b0;
               reg_code  <= '0;
               rm_code   <= '0;
               eff_addr  <= '0;
               seg_code  <= '0;
               phys_addr <= '0;
            end else begin
               out_valid <= in_valid;
               if (in_valid) begin
                  is_reg    <= n_reg;
                  reg_code  <= modrm[5:3];
                  rm_code   <= modrm[2:0];
                  eff_addr  <= n_ea;
                  seg_code  <= seg_sel;
                  phys_addr <= n_pa;
               end
            end
         end

         // R10: a result appears exactly one cycle after its request
         p_valid_follows_r10: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid == $past(in_valid));
         // R3: a register result comes only from mode 11
         p_regop_mode_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && is_reg) |-> ($past(modrm[7:6]) == 2'b11));
         // R7: an override names the segment of a memory operand
         p_override_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid && !is_reg && $past(ovr_en)) |-> (seg_code == $past(ovr_sel)));
         // R1: the field codes are taken from the sampled byte
         p_fields_r1: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid |-> (rm_code == $past(modrm[2:0]) && reg_code == $past(modrm[5:3])));
      end else begin : g_comb
         assign out_valid = in_valid;
         assign is_reg    = n_reg;
         assign reg_code  = modrm[5:3];
         assign rm_code   = modrm[2:0];
         assign eff_addr  = n_ea;
         assign seg_code  = seg_sel;
         assign phys_addr = n_pa;
      end
   endgenerate

   // R3: a register operand carries no address and uses the data code
   p_regop_no_addr_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && is_reg) |-> (eff_addr == '0 && phys_addr == '0 && seg_code == 2'b11));
endmodule

// File: tb/tb_seg_ea_gen.sv
module tb_seg_ea_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [7:0]  modrm = '0;
   logic [15:0] disp = '0, base_x = '0, base_p = '0, idx_s = '0, idx_d = '0;
   logic [15:0] seg_es = '0, seg_cs = '0, seg_ss = '0, seg_ds = '0;
   logic        ovr_en = 1'b0;
   logic [1:0]  ovr_sel = '0;
   logic        out_valid, is_reg;
   logic [2:0]  reg_code, rm_code;
   logic [15:0] eff_addr;
   logic [1:0]  seg_code;
   logic [19:0] phys_addr;

   int n_chk = 0;
   int n_bad = 0;

   always #2 clk = ~clk;

   seg_ea_gen dut (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .modrm(modrm), .disp(disp),
      .base_x(base_x), .base_p(base_p), .idx_s(idx_s), .idx_d(idx_d),
      .seg_es(seg_es), .seg_cs(seg_cs), .seg_ss(seg_ss), .seg_ds(seg_ds),
      .ovr_en(ovr_en), .ovr_sel(ovr_sel), .out_valid(out_valid), .is_reg(is_reg),
      .reg_code(reg_code), .rm_code(rm_code), .eff_addr(eff_addr),
      .seg_code(seg_code), .phys_addr(phys_addr));

   // expected results, from the requirement text
   logic        x_reg;
   logic [15:0] x_ea;
   logic [1:0]  x_seg;
   logic [19:0] x_pa;

   task automatic model();
      logic [1:0]  md;
      logic [2:0]  rm;
      logic [15:0] b, i, d, sv;
      logic        uses_p, direct;
      md = modrm[7:6];
      rm = modrm[2:0];
      b = 16'h0; i = 16'h0; d = 16'h0;
      direct = (md == 2'd0) && (rm == 3'd6);
      if (md == 2'd3) begin
         x_reg = 1'b1; x_ea = 16'h0; x_seg = 2'd3; x_pa = 20'h0;
      end else begin
         x_reg = 1'b0;
         case (rm)
            3'd0: begin b = base_x; i = idx_s; end
            3'd1: begin b = base_x; i = idx_d; end
            3'd2: begin b = base_p; i = idx_s; end
            3'd3: begin b = base_p; i = idx_d; end
            3'd4: i = idx_s;
            3'd5: i = idx_d;
            3'd6: b = direct ? 16'h0 : base_p;
            default: b = base_x;
         endcase
         if (md == 2'd1) d = {{8{disp[7]}}, disp[7:0]};
         else if (md == 2'd2 || direct) d = disp;
         x_ea = b + i + d;
         uses_p = (rm == 3'd2) || (rm == 3'd3) || (rm == 3'd6 && !direct);
         x_seg = ovr_en ? ovr_sel : (uses_p ? 2'd2 : 2'd3);
         case (x_seg)
            2'd0: sv = seg_es;
            2'd1: sv = seg_cs;
            2'd2: sv = seg_ss;
            default: sv = seg_ds;
         endcase
         x_pa = {sv, 4'h0} + {4'h0, x_ea};
      end
   endtask

   task automatic check(input string tag);
      model();
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b1 || is_reg !== x_reg || eff_addr !== x_ea || seg_code !== x_seg
          || phys_addr !== x_pa || reg_code !== modrm[5:3] || rm_code !== modrm[2:0]) begin
         n_bad++;
         $display("FAIL %s modrm=%02h: got v=%b reg=%b ea=%04h seg=%0d pa=%05h rc=%0d rm=%0d exp reg=%b ea=%04h seg=%0d pa=%05h rc=%0d rm=%0d",
                  tag, modrm, out_valid, is_reg, eff_addr, seg_code, phys_addr, reg_code, rm_code,
                  x_reg, x_ea, x_seg, x_pa, modrm[5:3], modrm[2:0]);
      end
   endtask

   task automatic set_pattern(input int p);
      case (p)
         0: begin base_x=16'h1234; base_p=16'h8000; idx_s=16'h00FF; idx_d=16'hFFF0; disp=16'h80F3;
                  seg_es=16'h1000; seg_cs=16'h2000; seg_ss=16'h3000; seg_ds=16'h4000; end
         1: begin base_x=16'hFFFF; base_p=16'hFFFE; idx_s=16'hFFFD; idx_d=16'hFFFC; disp=16'hFFFF;
                  seg_es=16'hFFFF; seg_cs=16'hF000; seg_ss=16'hFFF0; seg_ds=16'hFFFF; end
         2: begin base_x=16'h0101; base_p=16'h2468; idx_s=16'h1357; idx_d=16'h0ACE; disp=16'h7F7F;
                  seg_es=16'h93EE; seg_cs=16'h0001; seg_ss=16'hABCD; seg_ds=16'h5A5A; end
         default: begin base_x=16'h0; base_p=16'h0; idx_s=16'h0; idx_d=16'h0; disp=16'h1280;
                  seg_es=16'h0; seg_cs=16'h0; seg_ss=16'h0; seg_ds=16'h0; end
      endcase
   endtask

   task automatic drive(input logic [7:0] m, input logic oe, input logic [1:0] os);
      @(negedge clk);
      in_valid = 1'b1; modrm = m; ovr_en = oe; ovr_sel = os;
   endtask

   initial begin
      #1000000;
      n_chk++; n_bad++;
      $display("FAIL watchdog: got hung run, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      // R10 reset state
      n_chk++;
      if (out_valid !== 1'b0 || eff_addr !== 16'h0 || phys_addr !== 20'h0 || is_reg !== 1'b0) begin
         n_bad++;
         $display("FAIL R10 reset: got v=%b ea=%04h pa=%05h reg=%b expected all 0", out_valid, eff_addr, phys_addr, is_reg);
      end
      rst_n = 1'b1;

      // R8 worked example: segment 93EE, direct offset DB1E
      set_pattern(2);
      disp = 16'hDB1E;
      drive(8'h06, 1'b1, 2'd0);
      check("R8 example");
      n_chk++;
      if (phys_addr !== 20'hA19FE) begin
         n_bad++;
         $display("FAIL R8 example: got %05h expected A19FE", phys_addr);
      end

      // R9 offset wrap: base_x FFFF + idx_s 0002 -> 0001
      base_x = 16'hFFFF; idx_s = 16'h0002;
      drive(8'h00, 1'b0, 2'd0);
      check("R9 wrap");
      n_chk++;
      if (eff_addr !== 16'h0001) begin
         n_bad++;
         $display("FAIL R9 wrap: got %04h expected 0001", eff_addr);
      end

      // R8 physical wrap: data seg FFFF, offset 0010 -> 00000
      seg_ds = 16'hFFFF; disp = 16'h0010;
      drive(8'h06, 1'b0, 2'd0);
      check("R8 wrap");
      n_chk++;
      if (phys_addr !== 20'h00000) begin
         n_bad++;
         $display("FAIL R8 wrap: got %05h expected 00000", phys_addr);
      end

      // R4 high displacement byte has no effect in mode 01
      set_pattern(0);
      disp = 16'h0005;
      drive(8'h47, 1'b0, 2'd0);
      check("R4 s8 a");
      disp = 16'hA505;
      drive(8'h47, 1'b0, 2'd0);
      check("R4 s8 b");
      n_chk++;
      if (eff_addr !== 16'h1239) begin
         n_bad++;
         $display("FAIL R4 high byte ignored: got %04h expected 1239", eff_addr);
      end

      // R10 idle: out_valid drops one cycle after in_valid does
      @(negedge clk);
      in_valid = 1'b0;
      @(negedge clk);
      n_chk++;
      if (out_valid !== 1'b0) begin
         n_bad++;
         $display("FAIL R10 idle: got out_valid=%b expected 0", out_valid);
      end

      // sweep: every byte x patterns x override choices (R1 R2 R3 R4 R5 R6 R7)
      for (int p = 0; p < 4; p++) begin
         set_pattern(p);
         for (int m = 0; m < 256; m++) begin
            for (int o = 0; o < 5; o++) begin
               drive(m[7:0], (o != 0), o[1:0] - 2'd1);
               if (m[7:6] == 2'b11)                 check("R3 R1 register form");
               else if (o != 0)                     check("R7 override");
               else if (m[7:6] == 2'b00 && m[2:0] == 3'd6) check("R5 direct");
               else                                 check("R2 R4 R6 memory form");
            end
         end
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule